// File: doc/BRIEF.md
# Warp-Granular Named Barrier Unit

This unit keeps sixteen independent named barriers for the warps of one thread block. A warp that reaches a barrier offers one arrival. The arrival carries a 4-bit barrier number, an optional expected thread count, a mode bit and the warp's number of live (non-exited) threads. The mode bit selects either arrive-only, where the warp keeps running, or wait, where the warp stays blocked. Each barrier adds the live threads of every accepted warp to its running total. When the total reaches the expected count, the barrier completes. It then pulses a release line for every warp that arrived in wait mode, and it returns to idle in that same clock edge.

Each warp has its own request lane with valid and ready. A lane's request is accepted in any cycle in which its valid and ready are both high. A round-robin arbiter grants at most one lane per cycle, so ready is high only for the granted lane and only while that lane's valid is high. A lane that is not ready must hold valid and keep its payload stable until it is accepted. Faulty requests are still accepted, so the lane is freed. They are then discarded, and an error pulse names the class of fault. The warp scheduler holds a wait-mode warp until that warp's release pulse arrives.

Top module: `nbar_unit`

## Requirements
- R1: Barriers are selected by the 4-bit field `arr_bar`, with values 0 to 15. Arrivals on one barrier never change the total, count or release of any other barrier.
- R2: A request with `arr_has_cnt`=0 expects N_WARPS*WARP_SIZE threads. A request with `arr_has_cnt`=1 must carry a count that is non-zero, a multiple of WARP_SIZE and no larger than N_WARPS*WARP_SIZE. Any other count causes `err_bad_count` to pulse and the request to be discarded.
- R3: An arrive-only request (`arr_wait`=0) with `arr_has_cnt`=0 causes `err_no_count` to pulse and is discarded.
- R4: An accepted arrival adds the warp's `arr_live` value to the barrier total in a single step.
- R5: In the cycle after completion, `release_o` is high for exactly the warps that arrived in wait mode during that phase. Arrive-only warps get no pulse.
- R6: A barrier completes on the arrival that brings its total to or above the expected count. That same edge clears the barrier, so an arrival in the very next cycle begins a new phase.
- R7: Arrive-only and wait arrivals may be mixed on one barrier, and both kinds count toward completion.
- R8: The first arrival of a phase fixes the expected count for that phase. A later arrival in the same phase with a different count causes `err_mismatch` to pulse and is discarded.
- R9: A second arrival by the same warp on the same barrier before that barrier completes causes `err_dup` to pulse and is discarded.
- R10: At most one lane is ready per cycle, and only a lane whose valid is high. Grants rotate round-robin from the lane after the last grant, so a waiting lane is served within N_WARPS-1 cycles.
- R11: After reset all outputs are low. Each error flag pulses only in the cycle that follows an acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arr_valid | input | N_WARPS | Per-warp arrival request |
| arr_ready | output | N_WARPS | Per-warp acceptance (one-hot or zero) |
| arr_bar | input | 4*N_WARPS | Barrier number, 4 bits per warp |
| arr_has_cnt | input | N_WARPS | Count field present |
| arr_cnt | input | CNT_W*N_WARPS | Expected thread count per warp, CNT_W = clog2(N_WARPS*WARP_SIZE+1) |
| arr_wait | input | N_WARPS | 1 = wait mode, 0 = arrive-only |
| arr_live | input | LIVE_W*N_WARPS | Live thread count per warp, LIVE_W = clog2(WARP_SIZE+1) |
| release_o | output | N_WARPS | One-cycle release pulse per warp |
| err_no_count | output | 1 | Arrive-only request without a count |
| err_bad_count | output | 1 | Count zero, not warp-aligned, or too large |
| err_dup | output | 1 | Repeat arrival by a warp in one phase |
| err_mismatch | output | 1 | Count differs from the latched phase count |

## Verification
Some properties hold on every cycle, and these are checked all the time. Ready is one-hot and is never high without a matching valid. No lane is left waiting longer than the arbitration bound. A release pulse goes only to a warp that has an accepted wait-mode arrival still outstanding. Each error pulse follows an acceptance, and the no-count error has a matching arrive-only, uncounted request behind it. Other behaviours can only be shown by the directed scenarios. These are the exact completion cycle and release mask, the correct thread total when some threads have exited, reuse of a barrier in the cycle right after completion, the independence of the sixteen barriers, and the fact that discarded requests leave a barrier's total unchanged.

// File: rtl/nbar_pkg.sv
package nbar_pkg;
  localparam int BAR_NUM = 16;
  localparam int BAR_IDW = 4;

  typedef struct packed {
    logic no_cnt;
    logic bad_cnt;
    logic dup;
    logic mismatch;
  } nbar_err_t;
endpackage

// File: rtl/nbar_rr_arb.sv
module nbar_rr_arb #(
  parameter int N = 8,
  localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    req,
  output logic [N-1:0]    gnt,
  output logic [IDXW-1:0] gnt_idx
);
  logic [IDXW-1:0] ptr_q;

  // search starts at the pointer and wraps round
  always_comb begin
    logic found;
    found   = 1'b0;
    gnt     = '0;
    gnt_idx = '0;
    for (int i = 0; i < N; i++) begin
      int c;
      c = (int'(ptr_q) + i) % N;
      if (!found && req[c]) begin
        found   = 1'b1;
        gnt[c]  = 1'b1;
        gnt_idx = IDXW'(c);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else if (|req) ptr_q <= (int'(gnt_idx) == N - 1) ? '0 : gnt_idx + 1'b1;
  end
endmodule

// File: rtl/nbar_slot.sv
module nbar_slot #(
  parameter int N_WARPS = 8,
  parameter int CNT_W   = 9,
  parameter int LIVE_W  = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd,
  input  logic               is_wait,
  input  logic [N_WARPS-1:0] warp_oh,
  input  logic [LIVE_W-1:0]  live,
  input  logic [CNT_W-1:0]   req_exp,
  output logic               active,
  output logic [CNT_W-1:0]   exp_cnt,
  output logic [N_WARPS-1:0] seen_mask,
  output logic [N_WARPS-1:0] done_mask
);
  logic               act_q;
  logic [CNT_W-1:0]   exp_q;
  logic [CNT_W-1:0]   total_q;
  logic [N_WARPS-1:0] seen_q;
  logic [N_WARPS-1:0] wait_q;

  logic [CNT_W-1:0]   eff_exp;
  logic [CNT_W:0]     sum;
  logic               fire;
  logic [N_WARPS-1:0] add_wait;

  assign eff_exp  = act_q ? exp_q : req_exp;
  assign sum      = {1'b0, total_q} + (CNT_W+1)'(live);
  assign fire     = upd && (sum >= {1'b0, eff_exp});
  assign add_wait = is_wait ? warp_oh : '0;

  assign active    = act_q;
  assign exp_cnt   = exp_q;
  assign seen_mask = seen_q;
  assign done_mask = fire ? (wait_q | add_wait) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      exp_q   <= '0;
      total_q <= '0;
      seen_q  <= '0;
      wait_q  <= '0;
    end else if (fire) begin
      act_q   <= 1'b0;
      exp_q   <= '0;
      total_q <= '0;
      seen_q  <= '0;
      wait_q  <= '0;
    end else if (upd) begin
      act_q   <= 1'b1;
      exp_q   <= eff_exp;
      total_q <= sum[CNT_W-1:0];
      seen_q  <= seen_q | warp_oh;
      wait_q  <= wait_q | add_wait;
    end
  end
endmodule

// File: rtl/nbar_unit.sv
module nbar_unit #(
  parameter int N_WARPS   = 8,
  parameter int WARP_SIZE = 32
) (
  input  logic                                              clk,
  input  logic                                              rst_n,
  input  logic [N_WARPS-1:0]                                arr_valid,
  output logic [N_WARPS-1:0]                                arr_ready,
  input  logic [N_WARPS*4-1:0]                              arr_bar,
  input  logic [N_WARPS-1:0]                                arr_has_cnt,
  input  logic [N_WARPS*$clog2(N_WARPS*WARP_SIZE+1)-1:0]    arr_cnt,
  input  logic [N_WARPS-1:0]                                arr_wait,
  input  logic [N_WARPS*$clog2(WARP_SIZE+1)-1:0]            arr_live,
  output logic [N_WARPS-1:0]                                release_o,
  output logic                                              err_no_count,
  output logic                                              err_bad_count,
  output logic                                              err_dup,
  output logic                                              err_mismatch
);
  import nbar_pkg::*;

  localparam int BLOCK_THREADS = N_WARPS * WARP_SIZE;
  localparam int CNT_W  = $clog2(BLOCK_THREADS + 1);
  localparam int LIVE_W = $clog2(WARP_SIZE + 1);
  localparam int IDXW   = (N_WARPS > 1) ? $clog2(N_WARPS) : 1;
  localparam int WS_MASK = WARP_SIZE - 1;

  logic [N_WARPS-1:0] gnt;
  logic [IDXW-1:0]    g;
  logic               acc;

  nbar_rr_arb #(.N(N_WARPS)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (arr_valid),
    .gnt     (gnt),
    .gnt_idx (g)
  );

  assign arr_ready = gnt;
  assign acc       = |arr_valid;

  // fields of the granted lane
  logic [BAR_IDW-1:0] s_bar;
  logic               s_has;
  logic [CNT_W-1:0]   s_cnt;
  logic               s_wait;
  logic [LIVE_W-1:0]  s_live;
  logic [CNT_W-1:0]   s_exp;

  assign s_bar  = arr_bar[g*BAR_IDW +: BAR_IDW];
  assign s_has  = arr_has_cnt[g];
  assign s_cnt  = arr_cnt[g*CNT_W +: CNT_W];
  assign s_wait = arr_wait[g];
  assign s_live = arr_live[g*LIVE_W +: LIVE_W];
  assign s_exp  = s_has ? s_cnt : CNT_W'(BLOCK_THREADS);

  // per-barrier state
  logic [BAR_NUM-1:0] b_act;
  logic [CNT_W-1:0]   b_exp  [BAR_NUM];
  logic [N_WARPS-1:0] b_seen [BAR_NUM];
  logic [N_WARPS-1:0] b_done [BAR_NUM];
  logic [BAR_NUM-1:0] b_upd;

  nbar_err_t err_d;
  logic      req_ok;

  always_comb begin
    err_d          = '0;
    err_d.no_cnt   = !s_wait && !s_has;
    err_d.bad_cnt  = s_has && ((s_cnt == '0) ||
                               ((s_cnt & CNT_W'(WS_MASK)) != '0) ||
                               (s_cnt > CNT_W'(BLOCK_THREADS)));
    err_d.dup      = b_seen[s_bar][g];
    err_d.mismatch = b_act[s_bar] && !err_d.bad_cnt && !err_d.no_cnt &&
                     (s_exp != b_exp[s_bar]);
    req_ok         = acc && (err_d == '0);
  end

  for (genvar b = 0; b < BAR_NUM; b++) begin : g_bar
    assign b_upd[b] = req_ok && (s_bar == BAR_IDW'(b));
    nbar_slot #(
      .N_WARPS (N_WARPS),
      .CNT_W   (CNT_W),
      .LIVE_W  (LIVE_W)
    ) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd       (b_upd[b]),
      .is_wait   (s_wait),
      .warp_oh   (gnt),
      .live      (s_live),
      .req_exp   (s_exp),
      .active    (b_act[b]),
      .exp_cnt   (b_exp[b]),
      .seen_mask (b_seen[b]),
      .done_mask (b_done[b])
    );
  end

  logic [N_WARPS-1:0] rel_d;
  always_comb begin
    rel_d = '0;
    for (int b = 0; b < BAR_NUM; b++) rel_d |= b_done[b];
  end

  nbar_err_t err_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      release_o <= '0;
      err_q     <= '0;
    end else begin
      release_o <= rel_d;
      err_q     <= acc ? err_d : '0;
    end
  end

  assign err_no_count  = err_q.no_cnt;
  assign err_bad_count = err_q.bad_cnt;
  assign err_dup       = err_q.dup;
  assign err_mismatch  = err_q.mismatch;
endmodule

// File: rtl/nbar_sva.sv
module nbar_sva #(
  parameter int N_WARPS   = 8,
  parameter int WARP_SIZE = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N_WARPS-1:0]   arr_valid,
  input logic [N_WARPS-1:0]   arr_ready,
  input logic [N_WARPS-1:0]   arr_has_cnt,
  input logic [N_WARPS-1:0]   arr_wait,
  input logic [N_WARPS-1:0]   release_o,
  input logic                 err_no_count,
  input logic                 err_bad_count,
  input logic                 err_dup,
  input logic                 err_mismatch
);
  logic [N_WARPS-1:0] took;
  logic [N_WARPS-1:0] pend_q;
  logic               any_err;
  logic               nocnt_take;

  assign took       = arr_valid & arr_ready;
  assign any_err    = err_no_count | err_bad_count | err_dup | err_mismatch;
  assign nocnt_take = |(took & ~arr_wait & ~arr_has_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~release_o) | (took & arr_wait);
  end

  always_comb begin
    if (!rst_n) begin
      a_r11_reset_quiet: assert (release_o == '0 && !any_err);
    end
  end

  a_r10_ready_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(arr_ready));

  a_r10_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_ready & ~arr_valid) == '0);

  a_r5_release_only_waiters: assert property (@(posedge clk) disable iff (!rst_n)
    (release_o & ~pend_q) == '0);

  a_r11_err_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    any_err |-> $past(|took));

  a_r3_nocnt_cause: assert property (@(posedge clk) disable iff (!rst_n)
    err_no_count |-> $past(nocnt_take));

  for (genvar w = 0; w < N_WARPS; w++) begin : g_fair
    int unsigned starve_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) starve_q <= 0;
      else if (arr_valid[w] && !arr_ready[w]) starve_q <= starve_q + 1;
      else starve_q <= 0;
    end
    a_r10_no_starve: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_valid[w] && !arr_ready[w]) |-> (starve_q < N_WARPS - 1));
  end
endmodule

bind nbar_unit nbar_sva #(.N_WARPS(N_WARPS), .WARP_SIZE(WARP_SIZE)) u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .arr_valid     (arr_valid),
  .arr_ready     (arr_ready),
  .arr_has_cnt   (arr_has_cnt),
  .arr_wait      (arr_wait),
  .release_o     (release_o),
  .err_no_count  (err_no_count),
  .err_bad_count (err_bad_count),
  .err_dup       (err_dup),
  .err_mismatch  (err_mismatch)
);

// File: tb/tb_nbar_unit.sv
module tb_nbar_unit;
  localparam int NW     = 8;
  localparam int WS     = 32;
  localparam int CNT_W  = $clog2(NW*WS + 1);
  localparam int LIVE_W = $clog2(WS + 1);

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [NW-1:0]        arr_valid = '0;
  logic [NW-1:0]        arr_ready;
  logic [NW*4-1:0]      arr_bar;
  logic [NW-1:0]        arr_has_cnt;
  logic [NW*CNT_W-1:0]  arr_cnt;
  logic [NW-1:0]        arr_wait;
  logic [NW*LIVE_W-1:0] arr_live;
  logic [NW-1:0]        release_o;
  logic err_no_count, err_bad_count, err_dup, err_mismatch;

  logic [3:0]        q_bar  [NW];
  logic              q_has  [NW];
  logic [CNT_W-1:0]  q_cnt  [NW];
  logic              q_wait [NW];
  logic [LIVE_W-1:0] q_live [NW];

  always_comb begin
    for (int w = 0; w < NW; w++) begin
      arr_bar[w*4 +: 4]            = q_bar[w];
      arr_has_cnt[w]               = q_has[w];
      arr_cnt[w*CNT_W +: CNT_W]    = q_cnt[w];
      arr_wait[w]                  = q_wait[w];
      arr_live[w*LIVE_W +: LIVE_W] = q_live[w];
    end
  end

  nbar_unit #(.N_WARPS(NW), .WARP_SIZE(WS)) dut (.*);

  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] errs();
    return {err_no_count, err_bad_count, err_dup, err_mismatch};
  endfunction

  // one arrival on lane w; returns outputs seen in the following cycle
  task automatic arrive(input int w, input int bar, input bit has, input int cnt,
                        input bit wt, input int live,
                        output logic [NW-1:0] rel, output logic [3:0] e);
    @(negedge clk);
    q_bar[w] = 4'(bar); q_has[w] = has; q_cnt[w] = CNT_W'(cnt);
    q_wait[w] = wt; q_live[w] = LIVE_W'(live);
    arr_valid[w] = 1'b1;
    #1;
    check(arr_ready[w] === 1'b1, "R10 lone request granted", arr_ready, 1 << w);
    @(negedge clk);
    arr_valid[w] = 1'b0;
    rel = release_o;
    e   = errs();
  endtask

  task automatic t_reset();
    check(release_o == '0 && errs() == '0 && arr_ready == '0,
          "R11 reset quiet", {release_o, errs()}, 0);
  endtask

  task automatic t_full_block();
    logic [NW-1:0] r; logic [3:0] e;
    for (int w = 0; w < NW; w++) begin
      arrive(w, 3, 1'b0, 0, 1'b1, 32, r, e);
      if (w < NW-1) check(r == '0, "R6 no early completion", r, 0);
    end
    check(r == 8'hFF, "R5 full block release", r, 8'hFF);
    check(e == '0, "R2 default count no error", e, 0);
  endtask

  task automatic t_mixed_partial();
    logic [NW-1:0] r; logic [3:0] e;
    arrive(0, 5, 1'b1, 64, 1'b1, 20, r, e);
    arrive(1, 5, 1'b1, 64, 1'b0, 32, r, e);
    check(r == '0, "R4 52 of 64 not done", r, 0);
    arrive(2, 5, 1'b1, 64, 1'b1, 12, r, e);
    check(r == 8'b0000_0101, "R7 mixed release skips arrive-only", r, 8'b0000_0101);
    // immediate reuse with a new count
    arrive(1, 5, 1'b1, 32, 1'b1, 32, r, e);
    check(e == '0, "R8 new phase takes new count", e, 0);
    check(r == 8'b0000_0010, "R6 reuse next cycle", r, 8'b0000_0010);
  endtask

  task automatic t_independent();
    logic [NW-1:0] r; logic [3:0] e;
    arrive(0, 0, 1'b1, 64, 1'b1, 32, r, e);
    arrive(1, 15, 1'b1, 32, 1'b1, 32, r, e);
    check(r == 8'b0000_0010, "R1 barrier 15 alone", r, 8'b0000_0010);
    arrive(2, 0, 1'b1, 64, 1'b1, 32, r, e);
    check(r == 8'b0000_0101, "R1 barrier 0 kept its total", r, 8'b0000_0101);
  endtask

  task automatic t_count_errors();
    logic [NW-1:0] r; logic [3:0] e;
    arrive(3, 6, 1'b0, 0, 1'b0, 32, r, e);
    check(e == 4'b1000, "R3 arrive-only without count", e, 4'b1000);
    arrive(4, 7, 1'b1, 48, 1'b1, 32, r, e);
    check(e == 4'b0100, "R2 unaligned count", e, 4'b0100);
    arrive(4, 7, 1'b1, 0, 1'b1, 32, r, e);
    check(e == 4'b0100, "R2 zero count", e, 4'b0100);
    arrive(4, 7, 1'b1, 288, 1'b1, 32, r, e);
    check(e == 4'b0100, "R2 count over block", e, 4'b0100);
    // rejected requests left no trace: barriers 6 and 7 are idle
    arrive(3, 6, 1'b1, 64, 1'b1, 32, r, e);
    check(r == '0 && e == '0, "R3 discarded arrival not counted", r, 0);
    arrive(4, 6, 1'b1, 64, 1'b1, 32, r, e);
    check(r == 8'b0001_1000, "R3 barrier completes on valid arrivals", r, 8'b0001_1000);
    arrive(4, 7, 1'b1, 32, 1'b1, 32, r, e);
    check(r == 8'b0001_0000 && e == '0, "R2 barrier 7 clean after rejects", r, 8'b0001_0000);
  endtask

  task automatic t_mismatch();
    logic [NW-1:0] r; logic [3:0] e;
    arrive(0, 8, 1'b1, 64, 1'b1, 32, r, e);
    arrive(1, 8, 1'b1, 96, 1'b1, 32, r, e);
    check(e == 4'b0001, "R8 count mismatch flagged", e, 4'b0001);
    check(r == '0, "R8 mismatch not counted", r, 0);
    arrive(2, 8, 1'b1, 64, 1'b1, 32, r, e);
    check(r == 8'b0000_0101, "R8 latched count completes", r, 8'b0000_0101);
  endtask

  task automatic t_dup();
    logic [NW-1:0] r; logic [3:0] e;
    arrive(0, 9, 1'b1, 96, 1'b0, 32, r, e);
    arrive(0, 9, 1'b1, 96, 1'b1, 32, r, e);
    check(e == 4'b0010, "R9 repeat arrival flagged", e, 4'b0010);
    arrive(1, 9, 1'b1, 96, 1'b1, 32, r, e);
    check(r == '0, "R9 repeat not counted", r, 0);
    arrive(2, 9, 1'b1, 96, 1'b1, 32, r, e);
    check(r == 8'b0000_0110, "R9 release after true third warp", r, 8'b0000_0110);
  endtask

  task automatic t_round_robin();
    int prev = -1;
    @(negedge clk);
    for (int w = 0; w < NW; w++) begin
      q_bar[w] = 4'd10; q_has[w] = 1'b0; q_cnt[w] = '0;
      q_wait[w] = 1'b1; q_live[w] = LIVE_W'(32);
    end
    arr_valid = '1;
    for (int k = 0; k < NW; k++) begin
      int g = -1;
      #1;
      check($countones(arr_ready) == 1, "R10 one grant per cycle", arr_ready, 1);
      for (int w = 0; w < NW; w++) if (arr_ready[w]) g = w;
      if (prev >= 0) check(g == (prev + 1) % NW, "R10 rotating order", g, (prev + 1) % NW);
      prev = g;
      @(negedge clk);
      if (g >= 0) arr_valid[g] = 1'b0;
      if (k < NW-1) check(release_o == '0, "R6 contention no early release", release_o, 0);
    end
    check(release_o == 8'hFF, "R5 release after contention", release_o, 8'hFF);
  endtask

  initial begin
    for (int w = 0; w < NW; w++) begin
      q_bar[w] = '0; q_has[w] = 1'b0; q_cnt[w] = '0; q_wait[w] = 1'b0; q_live[w] = '0;
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_full_block();
    t_mixed_partial();
    t_independent();
    t_count_errors();
    t_mismatch();
    t_dup();
    t_round_robin();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule